// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block produces the read addresses and burst requests that one overlay window needs to pull its pixels out of a frame buffer in memory. Software programs a start address, which already includes the source crop offset (`crop_y × pitch + crop_x × bytes_per_pixel`). It also programs an end address equal to start plus `fb_width × win_height × bytes_per_pixel`, the number of bytes to fetch per line, the number of bytes to skip between lines, and a pixel-format code. On each frame-start pulse the block copies that configuration and walks the rectangle line by line. It issues word bursts whose maximum length depends on the pixel depth. The bus protocol behind the request port and the pixel unpacking that follows are handled elsewhere.

The sequencing is a four-state machine. `ST_IDLE` waits for a frame start. `ST_CHECK` runs at the start of every line and decides between fetching and finishing. `ST_BURST` holds a request until it is accepted. `ST_DONE` emits the end-of-frame pulse. The transitions are as follows. *frame_go* takes any state to `ST_CHECK` on `frame_start`. *line_go* moves from `ST_CHECK` to `ST_BURST` while the line-start address is below the end address. *frame_stop* moves from `ST_CHECK` to `ST_DONE` once that address is at or past the end address, or when the line length is zero. *burst_next* stays in `ST_BURST` when an accepted burst leaves bytes in the line. *line_wrap* moves from `ST_BURST` to `ST_CHECK` when an accepted burst finishes the line. *retire* moves from `ST_DONE` to `ST_IDLE`. A separate combinational test reports whether the current screen pixel falls inside the window rectangle.

Top module: `ovl_fetch_agen`

## Requirements
- R1: After reset `req_valid` and `frame_end` are low and stay low until a frame start.
- R2: A `frame_start` pulse copies all `cfg_*` inputs and reloads the address counter from `cfg_start_addr`, also in the middle of a frame. Changes to `cfg_*` after that pulse do not affect the bursts of the running frame.
- R3: Each line is fetched as consecutive bursts covering `cfg_line_bytes` bytes from the line start. The next line starts at the previous line start plus `cfg_line_bytes` plus `cfg_skip_bytes`.
- R4: A word is 4 bytes. The largest burst per format code is: code 0 (1 bpp) gives 4 words; codes 1, 2, 3 (2, 4, 8 bpp) give 8 words; codes 4, 5, 6 (16, 24, 32 bpp) give 16 words.
- R5: Code 7 (unrecognised depth) is handled as unpacked 24 bpp with 16-word bursts.
- R6: No burst crosses a line end. The last burst of a line is cut to ceil(remaining bytes / 4) words, and the next line starts at the exact byte position given in R3.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_words` hold. A new burst is offered only after the previous one was accepted.
- R8: At every line start, if the line address is at or above the copied end address, or the line length is zero, no further burst is issued and `frame_end` pulses high for exactly one cycle.
- R9: `win_hit` is high, combinationally, exactly when `win_left ≤ pix_x ≤ win_right` and `win_top ≤ pix_y ≤ win_bottom`. Both corners are inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse: copy configuration and restart the walk |
| cfg_start_addr | input | ADDR_W | First byte of the window in memory, crop offset included |
| cfg_end_addr | input | ADDR_W | Address at or beyond which no new line starts |
| cfg_line_bytes | input | LEN_W | Bytes fetched per line |
| cfg_skip_bytes | input | LEN_W | Bytes skipped after each line |
| cfg_fmt | input | 3 | Pixel-format code (see R4, R5) |
| req_ready | input | 1 | Burst accepted when high together with req_valid |
| req_valid | output | 1 | Burst request present |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_words | output | 5 | Burst length in 4-byte words, 1 to 16 |
| frame_end | output | 1 | One-cycle pulse when the frame fetch is finished |
| pix_x | input | COORD_W | Current screen column |
| pix_y | input | COORD_W | Current screen row |
| win_left | input | COORD_W | Window left column, inclusive |
| win_top | input | COORD_W | Window top row, inclusive |
| win_right | input | COORD_W | Window right column, inclusive |
| win_bottom | input | COORD_W | Window bottom row, inclusive |
| win_hit | output | 1 | Current pixel lies inside the window |

## Verification
The hardest situation to reach is a `frame_start` that arrives while a burst is waiting for acceptance in the middle of a frame. The bench runs a long frame with `req_ready` active until two bursts have been taken. It then withdraws `req_ready`, pulses `frame_start` with a different configuration, and checks that the next burst sequence starts at the new address with no end-of-frame pulse for the abandoned frame. Stall handling comes from varying `req_ready` across the table vectors: always high, every other cycle, and two cycles out of three. A line length that is not a multiple of the burst size, together with an end address that falls inside a line, exercises the shortened final burst and the per-line end test.

// File: rtl/ovl_fetch_pkg.sv
package ovl_fetch_pkg;

    localparam int FMT_W      = 3;
    localparam int MAX_BURST  = 16;
    localparam int BW_W       = $clog2(MAX_BURST + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_BURST,
        ST_DONE
    } agen_state_t;

    // Largest burst in words for a pixel-format code.
    function automatic logic [BW_W-1:0] burst_cap(input logic [FMT_W-1:0] code);
        logic [BW_W-1:0] cap;
        case (code)
            3'd0:                cap = BW_W'(4);
            3'd1, 3'd2, 3'd3:    cap = BW_W'(8);
            default:             cap = BW_W'(MAX_BURST);
        endcase
        return cap;
    endfunction

endpackage

// File: rtl/ovl_burst_sizer.sv
module ovl_burst_sizer
    import ovl_fetch_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [FMT_W-1:0] fmt,
    input  logic [LEN_W-1:0] rem_bytes,
    output logic [BW_W-1:0]  words,
    output logic [LEN_W-1:0] chunk_bytes
);

    logic [LEN_W:0]   rem_words;
    logic [BW_W-1:0]  cap;

    always_comb begin
        cap       = burst_cap(fmt);
        rem_words = ({1'b0, rem_bytes} + (LEN_W+1)'(3)) >> 2;
        if (rem_words <= (LEN_W+1)'(cap)) begin
            words       = BW_W'(rem_words);
            chunk_bytes = rem_bytes;
        end else begin
            words       = cap;
            chunk_bytes = LEN_W'({cap, 2'b00});
        end
    end

endmodule

// File: rtl/ovl_win_hit.sv
module ovl_win_hit #(
    parameter int COORD_W = 12
) (
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] left,
    input  logic [COORD_W-1:0] top,
    input  logic [COORD_W-1:0] right,
    input  logic [COORD_W-1:0] bottom,
    output logic               hit
);

    logic in_x, in_y;

    always_comb begin
        in_x = (pix_x >= left) && (pix_x <= right);
        in_y = (pix_y >= top)  && (pix_y <= bottom);
        hit  = in_x && in_y;
    end

endmodule

// File: rtl/ovl_fetch_fsm.sv
module ovl_fetch_fsm
    import ovl_fetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_end_addr,
    input  logic [LEN_W-1:0]  cfg_line_bytes,
    input  logic [LEN_W-1:0]  cfg_skip_bytes,
    input  logic [FMT_W-1:0]  cfg_fmt,
    input  logic              req_ready,
    input  logic [BW_W-1:0]   size_words,
    input  logic [LEN_W-1:0]  size_chunk,
    output logic [FMT_W-1:0]  fmt_q,
    output logic [LEN_W-1:0]  rem_q,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BW_W-1:0]   req_words,
    output logic              frame_end
);

    agen_state_t       state, state_nxt;
    logic [ADDR_W-1:0] addr_q, end_q;
    logic [LEN_W-1:0]  line_q, skip_q;
    logic              line_last;
    logic              accept;

    assign line_last = (size_chunk == rem_q);
    assign accept    = (state == ST_BURST) && req_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        if (frame_start) begin
            state_nxt = ST_CHECK;                       // frame_go
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_CHECK: begin
                    if ((addr_q >= end_q) || (line_q == '0))
                        state_nxt = ST_DONE;            // frame_stop
                    else
                        state_nxt = ST_BURST;           // line_go
                end
                ST_BURST: begin
                    if (req_ready && line_last)
                        state_nxt = ST_CHECK;           // line_wrap
                    else
                        state_nxt = ST_BURST;           // burst_next / hold
                end
                ST_DONE:  state_nxt = ST_IDLE;          // retire
            endcase
        end
    end

    // Address and line counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            end_q  <= '0;
            line_q <= '0;
            skip_q <= '0;
            rem_q  <= '0;
            fmt_q  <= '0;
        end else if (frame_start) begin
            addr_q <= cfg_start_addr;
            end_q  <= cfg_end_addr;
            line_q <= cfg_line_bytes;
            skip_q <= cfg_skip_bytes;
            rem_q  <= cfg_line_bytes;
            fmt_q  <= cfg_fmt;
        end else if (accept) begin
            if (line_last) begin
                addr_q <= addr_q + ADDR_W'(size_chunk) + ADDR_W'(skip_q);
                rem_q  <= line_q;
            end else begin
                addr_q <= addr_q + ADDR_W'(size_chunk);
                rem_q  <= rem_q - size_chunk;
            end
        end
    end

    // Outputs
    always_comb begin
        req_valid = (state == ST_BURST);
        frame_end = (state == ST_DONE);
        req_addr  = addr_q;
        req_words = size_words;
    end

    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !frame_start |=>
            req_valid && $stable(req_addr) && $stable(req_words));

    // R4
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_words != '0) && (req_words <= burst_cap(fmt_q)));

    // R6
    line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (size_chunk != '0) && (size_chunk <= rem_q));

    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (req_addr == $past(cfg_start_addr)) && !req_valid);

endmodule

// File: rtl/ovl_fetch_agen.sv
module ovl_fetch_agen
    import ovl_fetch_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [ADDR_W-1:0]  cfg_start_addr,
    input  logic [ADDR_W-1:0]  cfg_end_addr,
    input  logic [LEN_W-1:0]   cfg_line_bytes,
    input  logic [LEN_W-1:0]   cfg_skip_bytes,
    input  logic [2:0]         cfg_fmt,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [4:0]         req_words,
    output logic               frame_end,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] win_left,
    input  logic [COORD_W-1:0] win_top,
    input  logic [COORD_W-1:0] win_right,
    input  logic [COORD_W-1:0] win_bottom,
    output logic               win_hit
);

    logic [FMT_W-1:0] fmt_q;
    logic [LEN_W-1:0] rem_q;
    logic [BW_W-1:0]  size_words;
    logic [LEN_W-1:0] size_chunk;

    ovl_burst_sizer #(.LEN_W(LEN_W)) u_sizer (
        .fmt         (fmt_q),
        .rem_bytes   (rem_q),
        .words       (size_words),
        .chunk_bytes (size_chunk)
    );

    ovl_fetch_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start    (frame_start),
        .cfg_start_addr (cfg_start_addr),
        .cfg_end_addr   (cfg_end_addr),
        .cfg_line_bytes (cfg_line_bytes),
        .cfg_skip_bytes (cfg_skip_bytes),
        .cfg_fmt        (cfg_fmt),
        .req_ready      (req_ready),
        .size_words     (size_words),
        .size_chunk     (size_chunk),
        .fmt_q          (fmt_q),
        .rem_q          (rem_q),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_words      (req_words),
        .frame_end      (frame_end)
    );

    ovl_win_hit #(.COORD_W(COORD_W)) u_hit (
        .pix_x  (pix_x),
        .pix_y  (pix_y),
        .left   (win_left),
        .top    (win_top),
        .right  (win_right),
        .bottom (win_bottom),
        .hit    (win_hit)
    );

endmodule

// File: tb/ovl_fetch_agen_tb.sv
module ovl_fetch_agen_tb;

    localparam int NMAX = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [31:0] cfg_start_addr = '0, cfg_end_addr = '0;
    logic [15:0] cfg_line_bytes = '0, cfg_skip_bytes = '0;
    logic [2:0]  cfg_fmt = '0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [4:0]  req_words;
    logic        frame_end;
    logic [11:0] pix_x = '0, pix_y = '0;
    logic [11:0] win_left = '0, win_top = '0, win_right = '0, win_bottom = '0;
    logic        win_hit;

    always #4 clk = ~clk;

    ovl_fetch_agen u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
        .cfg_line_bytes(cfg_line_bytes), .cfg_skip_bytes(cfg_skip_bytes),
        .cfg_fmt(cfg_fmt), .req_ready(req_ready), .req_valid(req_valid),
        .req_addr(req_addr), .req_words(req_words), .frame_end(frame_end),
        .pix_x(pix_x), .pix_y(pix_y), .win_left(win_left), .win_top(win_top),
        .win_right(win_right), .win_bottom(win_bottom), .win_hit(win_hit)
    );

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor and ready driver
    int          cyc = 0;
    bit          rdy_en = 1'b0;
    int          rdy_pat = 0;
    logic [31:0] got_addr [NMAX];
    logic [4:0]  got_words [NMAX];
    int          got_n = 0;
    int          fe_cnt = 0;
    bit          fe_prev = 1'b0;
    bit          stall_prev = 1'b0;
    logic [31:0] stall_addr = '0;
    logic [4:0]  stall_words = '0;

    always @(negedge clk) begin
        bit nr;
        cyc++;
        unique case (rdy_pat)
            0: nr = 1'b1;
            1: nr = cyc[0];
            default: nr = (cyc % 3) != 0;
        endcase
        nr = nr && rdy_en;
        if (stall_prev && !frame_start) begin
            // R7: stalled request held
            check(req_valid && req_addr == stall_addr && req_words == stall_words,
                  "R7 hold", {req_addr, req_words}, {stall_addr, stall_words});
        end
        stall_prev  = req_valid && !nr && !frame_start;
        stall_addr  = req_addr;
        stall_words = req_words;
        if (req_valid && nr && got_n < NMAX) begin
            got_addr[got_n]  = req_addr;
            got_words[got_n] = req_words;
            got_n++;
        end
        if (frame_end) begin
            fe_cnt++;
            // R8: pulse lasts one cycle
            check(!fe_prev, "R8 pulse width", 1, 0);
        end
        fe_prev = frame_end;
        req_ready = nr;
    end

    // Expected model
    logic [31:0] exp_addr [NMAX];
    logic [4:0]  exp_words [NMAX];
    int          exp_n;
    int          exp_cap [NMAX];

    function automatic int cap_of(input logic [2:0] f);
        if (f == 3'd0) return 4;
        if (f <= 3'd3) return 8;
        return 16;
    endfunction

    task automatic build_exp(input logic [31:0] s, input logic [31:0] e,
                             input logic [15:0] ln, input logic [15:0] sk,
                             input logic [2:0] f);
        logic [31:0] ls;
        int rem, w, c, cap;
        exp_n = 0;
        cap = cap_of(f);
        ls = s;
        while (ls < e && ln != 0 && exp_n < NMAX) begin
            rem = int'(ln);
            while (rem > 0 && exp_n < NMAX) begin
                w = (rem + 3) / 4;
                if (w > cap) w = cap;
                c = (w * 4 < rem) ? w * 4 : rem;
                exp_addr[exp_n]  = ls + 32'(int'(ln) - rem);
                exp_words[exp_n] = 5'(w);
                exp_cap[exp_n]   = cap;
                exp_n++;
                rem -= c;
            end
            ls = ls + 32'(ln) + 32'(sk);
        end
    endtask

    task automatic wait_frame_end(input int fe0, input string req);
        int t = 0;
        while (fe_cnt == fe0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(fe_cnt == fe0 + 1, req, fe_cnt - fe0, 1);
    endtask

    task automatic compare(input string tag);
        check(got_n == exp_n, {tag, " R3 burst count"}, got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            check(got_addr[k] == exp_addr[k], {tag, " R3 address"}, got_addr[k], exp_addr[k]);
            if (exp_cap[k] == int'(exp_words[k]))
                check(got_words[k] == exp_words[k], {tag, " R4 full burst"}, got_words[k], exp_words[k]);
            else
                check(got_words[k] == exp_words[k], {tag, " R6 short burst"}, got_words[k], exp_words[k]);
        end
    endtask

    task automatic run_frame(input logic [31:0] s, input logic [31:0] e,
                             input logic [15:0] ln, input logic [15:0] sk,
                             input logic [2:0] f, input int pat, input string tag);
        int fe0;
        build_exp(s, e, ln, sk, f);
        @(negedge clk); #1;
        rdy_en = 1'b1; rdy_pat = pat; got_n = 0; fe0 = fe_cnt;
        cfg_start_addr = s; cfg_end_addr = e; cfg_line_bytes = ln;
        cfg_skip_bytes = sk; cfg_fmt = f; frame_start = 1'b1;
        @(negedge clk); #1;
        frame_start = 1'b0;
        // R2: scrambled configuration must not disturb the running frame
        cfg_start_addr = 32'hDEAD_0000; cfg_end_addr = 32'hFFFF_FFF0;
        cfg_line_bytes = 16'd3; cfg_skip_bytes = 16'd777; cfg_fmt = 3'd0;
        wait_frame_end(fe0, {tag, " R8 frame end"});
        compare(tag);
    endtask

    typedef struct packed {
        logic [31:0] start;
        logic [15:0] line;
        logic [15:0] skip;
        logic [7:0]  lines;
        logic [2:0]  fmt;
        logic [1:0]  pat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_1000, 16'd40,  16'd24, 8'd3, 3'd6, 2'd0},
        '{32'h0000_2000, 16'd100, 16'd0,  8'd2, 3'd4, 2'd1},
        '{32'h0000_3004, 16'd20,  16'd12, 8'd2, 3'd0, 2'd2},
        '{32'h0000_4000, 16'd70,  16'd10, 8'd2, 3'd3, 2'd1},
        '{32'h0000_5000, 16'd128, 16'd64, 8'd2, 3'd7, 2'd2},
        '{32'h0000_6000, 16'd32,  16'd0,  8'd1, 3'd1, 2'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_valid == 1'b0, "R1 valid in reset", req_valid, 0);
        check(frame_end == 1'b0, "R1 frame_end in reset", frame_end, 0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(req_valid == 1'b0 && fe_cnt == 0, "R1 idle after reset", req_valid, 0);

        // Table walk (R3 R4 R5 R6 R7 R8 R2)
        for (int i = 0; i < 6; i++) begin
            logic [31:0] e;
            e = VECS[i].start + (32'(VECS[i].line) + 32'(VECS[i].skip)) * 32'(VECS[i].lines);
            run_frame(VECS[i].start, e, VECS[i].line, VECS[i].skip,
                      VECS[i].fmt, int'(VECS[i].pat), $sformatf("vec%0d", i));
        end

        // R5: unrecognised code behaves as 16-word bursts
        run_frame(32'h7000, 32'h7000 + 32'd200, 16'd200, 16'd0, 3'd7, 0, "R5 fallback");

        // R8: end address inside a line stops at the next line start
        run_frame(32'h100, 32'h148, 16'd32, 16'd32, 3'd2, 1, "R8 mid end");
        // R8: empty frames
        run_frame(32'h800, 32'h800, 16'd64, 16'd0, 3'd4, 0, "R8 empty");
        run_frame(32'h800, 32'h900, 16'd0, 16'd4, 3'd4, 0, "R8 zero line");

        // R2: restart in the middle of a frame
        begin
            int fe0;
            @(negedge clk); #1;
            rdy_en = 1'b1; rdy_pat = 0; got_n = 0;
            cfg_start_addr = 32'hA000; cfg_end_addr = 32'hB000;
            cfg_line_bytes = 16'd256; cfg_skip_bytes = 16'd0; cfg_fmt = 3'd0;
            frame_start = 1'b1;
            @(negedge clk); #1 frame_start = 1'b0;
            while (got_n < 2) @(negedge clk);
            #1;
            rdy_en = 1'b0; fe0 = fe_cnt;
            build_exp(32'hC000, 32'hC000 + 32'd96, 16'd48, 16'd0, 3'd4);
            cfg_start_addr = 32'hC000; cfg_end_addr = 32'hC000 + 32'd96;
            cfg_line_bytes = 16'd48; cfg_skip_bytes = 16'd0; cfg_fmt = 3'd4;
            frame_start = 1'b1;
            @(negedge clk); #1;
            frame_start = 1'b0; got_n = 0; rdy_en = 1'b1;
            wait_frame_end(fe0, "R2 restart frame end");
            compare("R2 restart");
        end

        // R9: window hit test, inclusive corners
        #1;
        win_left = 12'd10; win_right = 12'd20; win_top = 12'd5; win_bottom = 12'd8;
        pix_x = 12'd10; pix_y = 12'd5;  #1 check(win_hit == 1'b1, "R9 top-left corner", win_hit, 1);
        pix_x = 12'd20; pix_y = 12'd8;  #1 check(win_hit == 1'b1, "R9 bottom-right corner", win_hit, 1);
        pix_x = 12'd15; pix_y = 12'd6;  #1 check(win_hit == 1'b1, "R9 interior", win_hit, 1);
        pix_x = 12'd21; pix_y = 12'd8;  #1 check(win_hit == 1'b0, "R9 right of window", win_hit, 0);
        pix_x = 12'd9;  pix_y = 12'd6;  #1 check(win_hit == 1'b0, "R9 left of window", win_hit, 0);
        pix_x = 12'd15; pix_y = 12'd4;  #1 check(win_hit == 1'b0, "R9 above window", win_hit, 0);
        pix_x = 12'd15; pix_y = 12'd9;  #1 check(win_hit == 1'b0, "R9 below window", win_hit, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule